// File: doc/BRIEF.md
# Checkpoint Event-Count Signature Monitor

This block watches a processor at run time through a set of event counters. Each counter is pointed at one of the per-cycle event strobes, and it accumulates that event between two checkpoint pulses. When a checkpoint arrives with its identifier, the counts of the window that just ended are judged against the stored signatures for that identifier. A signature gives an inclusive lower and upper bound for every counter. The window passes if at least one valid signature of that identifier contains all the counts. Otherwise an alert pulse is raised and the failing identifier is latched. The counters then restart, so that the next window begins.

Signatures are loaded through a simple write port. The port is open only while the lock input is low, so the table cannot change once monitoring has begun. Several signatures may be stored per checkpoint, one for each legitimate execution path. Counters saturate rather than wrap, so a runaway path cannot alias back into a legal range.

Top module: `hpc_ckpt_monitor`

## Requirements
- R1: There are NUM_CTR counters. Counter k takes its select value from bits [k*SEL_W +: SEL_W] of `evt_sel_i` and adds one in each cycle in which strobe `evt_i[select]` is high. A select value of NUM_EVT or more counts nothing.
- R2: A counter that has reached 2^CTR_W-1 stays there while more events arrive. It never wraps.
- R3: The window closed by a checkpoint holds only the events of the cycles strictly before the checkpoint cycle. An event in the checkpoint cycle is counted as the first event of the new window, and all counters restart from zero (or one) at that edge.
- R4: In the cycle after a checkpoint strobe, exactly one of `pass_o` and `alert_o` is high, each as a single-cycle pulse. Both are low in every cycle that does not follow a checkpoint.
- R5: A signature matches when, for every counter k, lo_k ≤ count_k ≤ hi_k, with both bounds inclusive. The bounds for counter k are bits [k*CTR_W +: CTR_W] of `wr_lo_i` and `wr_hi_i`.
- R6: Each checkpoint identifier has SIG_PER_CKPT signature slots. A match in any valid slot passes. A slot that is invalid or was never written never matches. After reset every slot is invalid, so every checkpoint alerts.
- R7: When `wr_en_i` is high and `lock_i` is low, the slot (`wr_ckpt_i`, `wr_slot_i`) takes the bounds and `wr_valid_i` at that edge. The new contents are first used by a checkpoint in a later cycle. With `lock_i` high, writes have no effect.
- R8: `fail_id_o` takes the checkpoint identifier in the cycle in which `alert_o` rises. It holds that value until the next alert. Reset sets it to 0.
- R9: During and right after reset, `pass_o`, `alert_o` and `fail_id_o` are 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Per-cycle event strobes from the monitored processor |
| evt_sel_i | input | NUM_CTR*SEL_W | Event select, one field per counter |
| ckpt_i | input | 1 | Checkpoint strobe, closes the window |
| ckpt_id_i | input | ID_W | Identifier of the checkpoint being reached |
| lock_i | input | 1 | High blocks all signature writes |
| wr_en_i | input | 1 | Signature write strobe |
| wr_ckpt_i | input | ID_W | Checkpoint identifier of the slot written |
| wr_slot_i | input | SLOT_W | Slot index within that identifier |
| wr_lo_i | input | NUM_CTR*CTR_W | Lower bounds, one field per counter |
| wr_hi_i | input | NUM_CTR*CTR_W | Upper bounds, one field per counter |
| wr_valid_i | input | 1 | Valid bit stored with the slot |
| pass_o | output | 1 | Pulse: the closed window matched a signature |
| alert_o | output | 1 | Pulse: the closed window matched no signature |
| fail_id_o | output | ID_W | Identifier of the most recent failing checkpoint |

## Verification
The bench builds the block with four counters, 62 event strobes, 4-bit counters, four checkpoint identifiers and two slots each. With 4-bit counters, saturation at 15 comes within a few dozen cycles, and a count of 40 would alias to 8 if the counters wrapped. Two slots per identifier let one window pass through the second path while the first rejects it. Unwritten identifiers exercise the empty-slot rule, and a locked write followed by an unlocked one exercises the write gate.

// File: rtl/hpc_mon_pkg.sv
package hpc_mon_pkg;

  // width helper: at least one bit even for a single entry
  function automatic int clog2_min1(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // one counter step: hold, increment, or stick at the ceiling
  function automatic int unsigned sat_step(int unsigned v, bit hit, int unsigned maxv);
    if (!hit)       return v;
    if (v >= maxv)  return maxv;
    return v + 1;
  endfunction

  // inclusive range test used by the signature compare
  function automatic bit in_window(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/hpc_evt_counter.sv
module hpc_evt_counter
  import hpc_mon_pkg::*;
#(
  parameter int NUM_EVT = 62,
  parameter int SEL_W   = 6,
  parameter int CTR_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               restart_i,
  output logic [CTR_W-1:0]   cnt_o
);
  localparam int unsigned CTR_MAX = (32'd1 << CTR_W) - 32'd1;

  logic [CTR_W-1:0] cnt_q;
  logic             evt_hit;
  logic             at_max;

  // selects beyond the implemented strobes see nothing
  assign evt_hit = (32'(sel_i) < NUM_EVT) ? evt_i[sel_i] : 1'b0;
  assign at_max  = (32'(cnt_q) == CTR_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= CTR_W'(sat_step(32'd0, evt_hit, CTR_MAX));
    end else begin
      cnt_q <= CTR_W'(sat_step(32'(cnt_q), evt_hit, CTR_MAX));
    end
  end

  assign cnt_o = cnt_q;

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && evt_hit && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && at_max) |=> at_max); // R2
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == {{(CTR_W-1){1'b0}}, $past(evt_hit)})); // R3

endmodule

// File: rtl/hpc_sig_table.sv
module hpc_sig_table
  import hpc_mon_pkg::*;
#(
  parameter int NUM_CTR      = 4,
  parameter int CTR_W        = 16,
  parameter int NUM_CKPT     = 8,
  parameter int SIG_PER_CKPT = 2,
  parameter int ID_W         = 3,
  parameter int SLOT_W       = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock_i,
  input  logic                     wr_en_i,
  input  logic [ID_W-1:0]          wr_ckpt_i,
  input  logic [SLOT_W-1:0]        wr_slot_i,
  input  logic [NUM_CTR*CTR_W-1:0] wr_lo_i,
  input  logic [NUM_CTR*CTR_W-1:0] wr_hi_i,
  input  logic                     wr_valid_i,
  input  logic [ID_W-1:0]          rd_ckpt_i,
  input  logic [NUM_CTR*CTR_W-1:0] cnt_vec_i,
  output logic                     match_o
);
  localparam int NUM_ENT = NUM_CKPT * SIG_PER_CKPT;
  localparam int IDX_W   = clog2_min1(NUM_ENT);

  logic [NUM_CTR*CTR_W-1:0] lo_q [NUM_ENT];
  logic [NUM_CTR*CTR_W-1:0] hi_q [NUM_ENT];
  logic [NUM_ENT-1:0]       valid_q;

  logic                     wr_ok;
  logic [IDX_W-1:0]         wr_idx;
  logic                     rd_id_ok;
  logic [SIG_PER_CKPT-1:0]  slot_hit;

  assign wr_ok  = wr_en_i && !lock_i
                  && (32'(wr_ckpt_i) < NUM_CKPT)
                  && (32'(wr_slot_i) < SIG_PER_CKPT);
  assign wr_idx = IDX_W'(32'(wr_ckpt_i) * SIG_PER_CKPT + 32'(wr_slot_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_ok) begin
      valid_q[wr_idx] <= wr_valid_i;
    end
  end

  // bounds carry no reset: an entry is only read once its valid bit is set
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      lo_q[wr_idx] <= wr_lo_i;
      hi_q[wr_idx] <= wr_hi_i;
    end
  end

  assign rd_id_ok = (32'(rd_ckpt_i) < NUM_CKPT);

  for (genvar s = 0; s < SIG_PER_CKPT; s++) begin : g_slot
    logic [IDX_W-1:0]   idx;
    logic [NUM_CTR-1:0] ctr_ok;
    assign idx = IDX_W'(32'(rd_ckpt_i) * SIG_PER_CKPT + s);
    for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
      assign ctr_ok[c] = in_window(32'(cnt_vec_i[c*CTR_W +: CTR_W]),
                                   32'(lo_q[idx][c*CTR_W +: CTR_W]),
                                   32'(hi_q[idx][c*CTR_W +: CTR_W]));
    end
    assign slot_hit[s] = rd_id_ok && valid_q[idx] && (&ctr_ok);
  end

  assign match_o = |slot_hit;

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(valid_q)); // R7

endmodule

// File: rtl/hpc_ckpt_monitor.sv
module hpc_ckpt_monitor
  import hpc_mon_pkg::*;
#(
  parameter int NUM_CTR      = 4,
  parameter int NUM_EVT      = 62,
  parameter int CTR_W        = 16,
  parameter int NUM_CKPT     = 8,
  parameter int SIG_PER_CKPT = 2,
  localparam int SEL_W       = clog2_min1(NUM_EVT),
  localparam int ID_W        = clog2_min1(NUM_CKPT),
  localparam int SLOT_W      = clog2_min1(SIG_PER_CKPT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EVT-1:0]       evt_i,
  input  logic [NUM_CTR*SEL_W-1:0] evt_sel_i,
  input  logic                     ckpt_i,
  input  logic [ID_W-1:0]          ckpt_id_i,
  input  logic                     lock_i,
  input  logic                     wr_en_i,
  input  logic [ID_W-1:0]          wr_ckpt_i,
  input  logic [SLOT_W-1:0]        wr_slot_i,
  input  logic [NUM_CTR*CTR_W-1:0] wr_lo_i,
  input  logic [NUM_CTR*CTR_W-1:0] wr_hi_i,
  input  logic                     wr_valid_i,
  output logic                     pass_o,
  output logic                     alert_o,
  output logic [ID_W-1:0]          fail_id_o
);
  logic [NUM_CTR*CTR_W-1:0] cnt_vec;
  logic                     window_close;
  logic                     sig_match;
  logic                     pass_q;
  logic                     alert_q;
  logic [ID_W-1:0]          fail_id_q;

  assign window_close = ckpt_i;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    hpc_evt_counter #(
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W),
      .CTR_W   (CTR_W)
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .sel_i     (evt_sel_i[k*SEL_W +: SEL_W]),
      .restart_i (window_close),
      .cnt_o     (cnt_vec[k*CTR_W +: CTR_W])
    );
  end

  hpc_sig_table #(
    .NUM_CTR      (NUM_CTR),
    .CTR_W        (CTR_W),
    .NUM_CKPT     (NUM_CKPT),
    .SIG_PER_CKPT (SIG_PER_CKPT),
    .ID_W         (ID_W),
    .SLOT_W       (SLOT_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_i     (lock_i),
    .wr_en_i    (wr_en_i),
    .wr_ckpt_i  (wr_ckpt_i),
    .wr_slot_i  (wr_slot_i),
    .wr_lo_i    (wr_lo_i),
    .wr_hi_i    (wr_hi_i),
    .wr_valid_i (wr_valid_i),
    .rd_ckpt_i  (ckpt_id_i),
    .cnt_vec_i  (cnt_vec),
    .match_o    (sig_match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q    <= 1'b0;
      alert_q   <= 1'b0;
      fail_id_q <= '0;
    end else begin
      pass_q  <= window_close && sig_match;
      alert_q <= window_close && !sig_match;
      if (window_close && !sig_match) begin
        fail_id_q <= ckpt_id_i;
      end
    end
  end

  assign pass_o    = pass_q;
  assign alert_o   = alert_q;
  assign fail_id_o = fail_id_q;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_o, alert_o})); // R4
  AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_i |=> (pass_o || alert_o)); // R4
  AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !ckpt_i |=> (!pass_o && !alert_o)); // R4
  AST_FAIL_ID_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_i |=> (!alert_o || fail_id_o == $past(ckpt_id_i))); // R8
  AST_FAIL_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_o |-> $stable(fail_id_o)); // R8

endmodule

// File: tb/hpc_ckpt_monitor_tb.sv
module hpc_ckpt_monitor_tb;
  localparam int NC   = 4;
  localparam int NE   = 62;
  localparam int SW   = 6;
  localparam int CW   = 4;
  localparam int NK   = 4;
  localparam int NS   = 2;
  localparam int IW   = 2;
  localparam int SLW  = 1;
  localparam int MAXC = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NE-1:0]     evt = '0;
  logic [NC*SW-1:0]  sel = '0;
  logic              ckpt = 1'b0;
  logic [IW-1:0]     ckpt_id = '0;
  logic              lock = 1'b0;
  logic              wr_en = 1'b0;
  logic [IW-1:0]     wr_ckpt = '0;
  logic [SLW-1:0]    wr_slot = '0;
  logic [NC*CW-1:0]  wr_lo = '0;
  logic [NC*CW-1:0]  wr_hi = '0;
  logic              wr_valid = 1'b0;
  logic              pass_o;
  logic              alert_o;
  logic [IW-1:0]     fail_id_o;

  always #5 clk = ~clk;

  hpc_ckpt_monitor #(
    .NUM_CTR(NC), .NUM_EVT(NE), .CTR_W(CW), .NUM_CKPT(NK), .SIG_PER_CKPT(NS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .evt_sel_i(sel),
    .ckpt_i(ckpt), .ckpt_id_i(ckpt_id), .lock_i(lock),
    .wr_en_i(wr_en), .wr_ckpt_i(wr_ckpt), .wr_slot_i(wr_slot),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_valid_i(wr_valid),
    .pass_o(pass_o), .alert_o(alert_o), .fail_id_o(fail_id_o)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R9";

  // behavioural reference state
  int m_cnt [NC];
  int m_lo  [NK][NS][NC];
  int m_hi  [NK][NS][NC];
  bit m_val [NK][NS];
  bit e_pass = 0;
  bit e_alert = 0;
  int e_fid = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit model_match(int id);
    for (int s = 0; s < NS; s++) begin
      bit ok = m_val[id][s];
      for (int c = 0; c < NC; c++)
        if (m_cnt[c] < m_lo[id][s][c] || m_cnt[c] > m_hi[id][s][c]) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  function automatic logic [NC*CW-1:0] pack4(int a, int b, int c, int d);
    return {CW'(d), CW'(c), CW'(b), CW'(a)};
  endfunction

  // one clock: model predicts from the inputs now applied, then compare after the edge
  task automatic cyc();
    if (ckpt) begin
      bit m = model_match(int'(ckpt_id));
      e_pass = m;
      e_alert = !m;
      if (!m) e_fid = int'(ckpt_id);
    end else begin
      e_pass = 0;
      e_alert = 0;
    end
    for (int c = 0; c < NC; c++) begin
      int s = int'(sel[c*SW +: SW]);
      int h = (s < NE) ? int'(evt[s]) : 0;
      if (ckpt) m_cnt[c] = h;
      else if (m_cnt[c] + h > MAXC) m_cnt[c] = MAXC;
      else m_cnt[c] = m_cnt[c] + h;
    end
    if (wr_en && !lock) begin
      m_val[wr_ckpt][wr_slot] = wr_valid;
      for (int c = 0; c < NC; c++) begin
        m_lo[wr_ckpt][wr_slot][c] = int'(wr_lo[c*CW +: CW]);
        m_hi[wr_ckpt][wr_slot][c] = int'(wr_hi[c*CW +: CW]);
      end
    end
    @(posedge clk);
    #1;
    check(cur_req, "pass_o", int'(pass_o), int'(e_pass));
    check(cur_req, "alert_o", int'(alert_o), int'(e_alert));
    check("R8", "fail_id_o", int'(fail_id_o), e_fid);
  endtask

  task automatic write_sig(int ck, int sl, logic [NC*CW-1:0] lo, logic [NC*CW-1:0] hi, bit v);
    wr_en = 1; wr_ckpt = IW'(ck); wr_slot = SLW'(sl); wr_lo = lo; wr_hi = hi; wr_valid = v;
    cyc();
    wr_en = 0;
  endtask

  task automatic pulse(logic [NE-1:0] mask, int n);
    for (int i = 0; i < n; i++) begin
      evt = mask;
      cyc();
    end
    evt = '0;
  endtask

  task automatic checkpoint(int id, string req, bit exp_pass);
    ckpt = 1; ckpt_id = IW'(id);
    cyc();
    ckpt = 0;
    check(req, "verdict pass", int'(pass_o), int'(exp_pass));
  endtask

  function automatic logic [NE-1:0] bit_of(int b);
    return NE'(1) << b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) m_cnt[c] = 0;
    for (int k = 0; k < NK; k++)
      for (int s = 0; s < NS; s++) m_val[k][s] = 0;
    // select: ctr0<-evt5, ctr1<-evt61, ctr2<-evt0, ctr3<-63 (beyond range)
    sel = {SW'(63), SW'(0), SW'(61), SW'(5)};
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset pass_o", int'(pass_o), 0);
    check("R9", "reset alert_o", int'(alert_o), 0);
    check("R9", "reset fail_id_o", int'(fail_id_o), 0);
    rst_n = 1;
    cyc();

    // R6: empty table alerts
    cur_req = "R6";
    checkpoint(1, "R6", 0);

    // R5: inclusive bounds, exact edge values
    cur_req = "R5";
    write_sig(1, 0, pack4(3, 2, 0, 0), pack4(3, 4, 15, 0), 1);
    pulse(bit_of(5) | bit_of(61) | bit_of(0), 2);
    pulse(bit_of(5), 1);
    checkpoint(1, "R5", 1);
    // one above upper bound
    pulse(bit_of(5) | bit_of(61), 4);
    checkpoint(1, "R5", 0);
    check("R8", "fail id after alert", int'(fail_id_o), 1);

    // R6: second path slot accepts what slot 0 rejects
    cur_req = "R6";
    write_sig(1, 1, pack4(6, 0, 0, 0), pack4(8, 15, 15, 0), 1);
    pulse(bit_of(5), 7);
    checkpoint(1, "R6", 1);
    check("R8", "fail id held over pass", int'(fail_id_o), 1);
    checkpoint(2, "R6", 0);
    check("R8", "fail id new alert", int'(fail_id_o), 2);

    // R3: event in checkpoint cycle belongs to next window
    cur_req = "R3";
    pulse(bit_of(5) | bit_of(61), 2);
    evt = bit_of(5);
    checkpoint(1, "R3", 0);
    evt = '0;
    pulse(bit_of(5) | bit_of(61), 2);
    checkpoint(1, "R3", 1);

    // R2: saturation at 15 instead of wrap (40 mod 16 = 8)
    cur_req = "R2";
    write_sig(3, 0, pack4(15, 0, 0, 0), pack4(15, 15, 15, 0), 1);
    pulse(bit_of(5), 40);
    checkpoint(3, "R2", 1);
    pulse(bit_of(5), 14);
    checkpoint(3, "R2", 0);
    check("R8", "fail id sat window", int'(fail_id_o), 3);

    // R7: locked writes ignored, unlocked writes take effect
    cur_req = "R7";
    lock = 1;
    write_sig(2, 0, pack4(0, 0, 0, 0), pack4(15, 15, 15, 15), 1);
    write_sig(1, 0, pack4(0, 0, 0, 0), pack4(0, 0, 0, 0), 0);
    checkpoint(2, "R7", 0);
    pulse(bit_of(5) | bit_of(61), 3);
    checkpoint(1, "R7", 1);
    lock = 0;
    write_sig(2, 0, pack4(0, 0, 0, 0), pack4(15, 15, 15, 15), 1);
    checkpoint(2, "R7", 1);
    // invalidating a slot removes it
    write_sig(2, 0, pack4(0, 0, 0, 0), pack4(15, 15, 15, 15), 0);
    checkpoint(2, "R6", 0);

    // R1: retarget ctr0 to evt10; evt5 no longer counts
    cur_req = "R1";
    sel = {SW'(63), SW'(0), SW'(61), SW'(10)};
    cyc();
    pulse(bit_of(5) | bit_of(61), 3);
    checkpoint(1, "R1", 0);
    pulse(bit_of(10) | bit_of(61), 3);
    checkpoint(1, "R1", 1);
    // ctr3 at select 62 still sees nothing even with every strobe high
    sel = {SW'(62), SW'(0), SW'(61), SW'(10)};
    cyc();
    checkpoint(1, "R1", 0);
    pulse('1, 3);
    checkpoint(1, "R1", 1);

    cur_req = "R4";
    repeat (3) cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule